// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between an in-order core's single load/store port and a memory bus that allows one transaction in flight at a time. Memory stores are accepted into a small FIFO and return to the core at once. The buffer then writes them out to memory in the order they were accepted. A load whose word address matches no buffered store goes to memory ahead of the queued stores. A load whose address matches a buffered store takes its data from the youngest matching entry, as long as that entry supplies every byte the load asks for. If that entry supplies only some of the bytes, the load waits until the entry has left the buffer.

Five event inputs stand for a locked operation, a store fence, a full fence, an interrupt or exception, and a serializing instruction. Each one stops the core until the buffer is empty. I/O reads and writes never enter the buffer. They go to the bus only once every buffered memory write has drained. While any of this holds the core back, it sees back-pressure on its ready/valid handshake, and `core_hold` shows that a drain is in progress.

Top module: `sbuf_top`

## Requirements
- R1: Buffered stores reach the bus in exactly the order they were accepted, and after a full drain memory equals the program-order result of all stores.
- R2: A load whose word address matches no buffered entry is issued on the bus while older stores are still buffered.
- R3: A load whose youngest matching entry covers all of its byte enables (bit i of `core_be` selects byte i) completes in the cycle it is presented, with that entry's data and without a bus read.
- R4: A load whose youngest matching entry covers only some of its byte enables is stalled until no matching entry remains, and is then read from memory.
- R5: While any event input is raised and the buffer is not empty, `core_hold` is 1 and no new request is accepted. The hold persists after the event drops, until the buffer is empty.
- R6: An I/O write (`core_kind` 3) is never buffered and is issued on the bus with `mem_io`=1 only when the buffer is empty.
- R7: An I/O read (`core_kind` 2) is issued only when the buffer is empty and returns the I/O location's data.
- R8: When all DEPTH entries are occupied, a new store (`core_kind` 1) is not accepted until an entry retires.
- R9: A bus request holds `mem_req`, address, direction and data steady until `mem_ack`, and at most one request is outstanding.
- R10: After reset the buffer is empty, no bus request is raised and `core_hold` is 0.
- R11: `sb_empty` is 0 while any store is buffered and 1 once all have been written. A load (`core_kind` 0) returns program-order data in every case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present |
| core_kind | input | 2 | 0 load, 1 store, 2 I/O read, 3 I/O write |
| core_addr | input | AW | Word address |
| core_wdata | input | DW | Store data |
| core_be | input | DW/8 | Byte enables |
| core_ready | output | 1 | Request accepted / completed this cycle |
| core_rdata | output | DW | Load data, valid with core_ready |
| ev_locked | input | 1 | Locked operation drain event |
| ev_store_fence | input | 1 | Store fence drain event |
| ev_full_fence | input | 1 | Full fence drain event |
| ev_interrupt | input | 1 | Interrupt or exception drain event |
| ev_serialize | input | 1 | Serializing instruction drain event |
| core_hold | output | 1 | Core stalled for drain |
| sb_empty | output | 1 | No store buffered |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write |
| mem_io | output | 1 | Bus access targets I/O space |
| mem_addr | output | AW | Bus word address |
| mem_wdata | output | DW | Bus write data |
| mem_be | output | DW/8 | Bus byte enables |
| mem_ack | input | 1 | Bus completion, one cycle |
| mem_rdata | input | DW | Bus read data, valid with mem_ack |

## Verification
The bench builds the block with DEPTH=4, AW=4 and DW=32. The 16-word address space makes aliasing between loads and buffered stores frequent. Four stores are enough to fill the buffer. The sweep stores to every address under each of four byte-enable patterns and then loads the full word back, which reaches both the forwarding case and the partial-overlap stall. A stalled bus and a variable bus latency keep stores buffered long enough to test load bypass, each drain event and full-buffer back-pressure. A pseudo-random mix of all four request kinds then runs against a program-order reference model.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_IORD  = 2'd2,
    OP_IOWR  = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ST,
    BS_LD,
    BS_IO,
    BS_RSP
  } bus_st_e;

  // ring position of the entry 'step' places after 'base'
  function automatic int ring_idx(input int base, input int step, input int depth);
    return (base + step) % depth;
  endfunction

  // every byte wanted by 'need' is present in 'have'
  function automatic logic bytes_cover(input logic [15:0] need, input logic [15:0] have);
    return (need & ~have) == 16'd0;
  endfunction

endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int BEW  = DW / 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [AW-1:0]  push_addr,
  input  logic [DW-1:0]  push_data,
  input  logic [BEW-1:0] push_be,
  input  logic           pop,
  output logic [AW-1:0]  e_addr [DEPTH],
  output logic [DW-1:0]  e_data [DEPTH],
  output logic [BEW-1:0] e_be   [DEPTH],
  output logic [PW-1:0]  head_idx,
  output logic [CW-1:0]  count,
  output logic           full,
  output logic           empty
);
  import sbuf_pkg::*;

  logic [PW-1:0] head_q;
  logic [CW-1:0] count_q;
  logic [PW-1:0] tail_idx;

  assign tail_idx = PW'(ring_idx(int'(head_q), int'(count_q), DEPTH));
  assign full     = (count_q == CW'(DEPTH));
  assign empty    = (count_q == '0);
  assign head_idx = head_q;
  assign count    = count_q;

  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[tail_idx] <= push_addr;
      e_data[tail_idx] <= push_data;
      e_be[tail_idx]   <= push_be;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop) head_q <= PW'(ring_idx(int'(head_q), 1, DEPTH));
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> count_q < CW'(DEPTH));
  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count_q != '0);
  p_empty_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> !empty);

endmodule

// File: rtl/sbuf_match.sv
module sbuf_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int BEW  = DW / 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0]  e_addr [DEPTH],
  input  logic [DW-1:0]  e_data [DEPTH],
  input  logic [BEW-1:0] e_be   [DEPTH],
  input  logic [PW-1:0]  head_idx,
  input  logic [CW-1:0]  count,
  input  logic [AW-1:0]  ld_addr,
  input  logic [BEW-1:0] ld_be,
  output logic           hit,
  output logic           covers,
  output logic [DW-1:0]  fwd_data
);
  import sbuf_pkg::*;

  logic [BEW-1:0] sel_be;

  // walk oldest to youngest; the last match left standing is the youngest
  always_comb begin
    hit      = 1'b0;
    fwd_data = '0;
    sel_be   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (k < int'(count) &&
          e_addr[PW'(ring_idx(int'(head_idx), k, DEPTH))] == ld_addr) begin
        hit      = 1'b1;
        fwd_data = e_data[PW'(ring_idx(int'(head_idx), k, DEPTH))];
        sel_be   = e_be[PW'(ring_idx(int'(head_idx), k, DEPTH))];
      end
    end
    covers = hit && bytes_cover(16'(ld_be), 16'(sel_be));
  end

endmodule

// File: rtl/sbuf_bus.sv
module sbuf_bus #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  localparam int BEW = DW / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  sbuf_pkg::op_kind_e  req_kind,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [BEW-1:0]      req_be,
  input  logic                hold,
  input  logic                fwd_hit,
  input  logic                sb_empty,
  input  logic [AW-1:0]       head_addr,
  input  logic [DW-1:0]       head_data,
  input  logic [BEW-1:0]      head_be,
  input  logic                mem_ack,
  input  logic [DW-1:0]       mem_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_io,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  output logic [BEW-1:0]      mem_be,
  output logic                pop,
  output logic                done,
  output logic [DW-1:0]       rsp_data
);
  import sbuf_pkg::*;

  bus_st_e state_q;
  logic    start_ld, start_io, start_st, is_io_kind;

  assign is_io_kind = (req_kind == OP_IORD) || (req_kind == OP_IOWR);
  assign start_ld = (state_q == BS_IDLE) && req_valid && !hold &&
                    (req_kind == OP_LOAD) && !fwd_hit;
  assign start_io = (state_q == BS_IDLE) && req_valid && !hold &&
                    is_io_kind && sb_empty;
  assign start_st = (state_q == BS_IDLE) && !start_ld && !start_io && !sb_empty;
  assign pop      = (state_q == BS_ST) && mem_ack;
  assign done     = (state_q == BS_RSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= BS_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_io    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      rsp_data  <= '0;
    end else begin
      case (state_q)
        BS_IDLE: begin
          if (start_ld || start_io) begin
            mem_req   <= 1'b1;
            mem_we    <= (req_kind == OP_IOWR);
            mem_io    <= start_io;
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
            mem_be    <= req_be;
            state_q   <= start_ld ? BS_LD : BS_IO;
          end else if (start_st) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_io    <= 1'b0;
            mem_addr  <= head_addr;
            mem_wdata <= head_data;
            mem_be    <= head_be;
            state_q   <= BS_ST;
          end
        end
        BS_ST: if (mem_ack) begin
          mem_req <= 1'b0;
          state_q <= BS_IDLE;
        end
        BS_LD, BS_IO: if (mem_ack) begin
          mem_req  <= 1'b0;
          rsp_data <= mem_rdata;
          state_q  <= BS_RSP;
        end
        default: state_q <= BS_IDLE;
      endcase
    end
  end

  p_req_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_io_after_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_io |-> sb_empty);
  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);

endmodule

// File: rtl/sbuf_top.sv
module sbuf_top #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int BEW  = DW / 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           core_valid,
  input  logic [1:0]     core_kind,
  input  logic [AW-1:0]  core_addr,
  input  logic [DW-1:0]  core_wdata,
  input  logic [BEW-1:0] core_be,
  output logic           core_ready,
  output logic [DW-1:0]  core_rdata,
  input  logic           ev_locked,
  input  logic           ev_store_fence,
  input  logic           ev_full_fence,
  input  logic           ev_interrupt,
  input  logic           ev_serialize,
  output logic           core_hold,
  output logic           sb_empty,
  output logic           mem_req,
  output logic           mem_we,
  output logic           mem_io,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic [BEW-1:0] mem_be,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata
);
  import sbuf_pkg::*;

  op_kind_e       kind;
  logic           ev_any, drain_pend_q;
  logic           st_go, fwd_go, push, pop, bus_done;
  logic           fifo_full, fifo_empty, hit, covers;
  logic [AW-1:0]  e_addr [DEPTH];
  logic [DW-1:0]  e_data [DEPTH];
  logic [BEW-1:0] e_be   [DEPTH];
  logic [PW-1:0]  head_idx;
  logic [CW-1:0]  count;
  logic [DW-1:0]  fwd_data, rsp_data;

  assign kind   = op_kind_e'(core_kind);
  assign ev_any = ev_locked | ev_store_fence | ev_full_fence | ev_interrupt | ev_serialize;

  // a drain stays requested until the last buffered store has retired
  assign core_hold = (ev_any | drain_pend_q) & !fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) drain_pend_q <= 1'b0;
    else        drain_pend_q <= core_hold;
  end

  assign st_go      = core_valid && (kind == OP_STORE) && !core_hold && !fifo_full;
  assign fwd_go     = core_valid && (kind == OP_LOAD) && !core_hold && covers;
  assign push       = st_go;
  assign core_ready = st_go | fwd_go | bus_done;
  assign core_rdata = bus_done ? rsp_data : fwd_data;
  assign sb_empty   = fifo_empty;

  sbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk, .rst_n, .push,
    .push_addr(core_addr), .push_data(core_wdata), .push_be(core_be),
    .pop, .e_addr, .e_data, .e_be, .head_idx, .count,
    .full(fifo_full), .empty(fifo_empty)
  );

  sbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .e_addr, .e_data, .e_be, .head_idx, .count,
    .ld_addr(core_addr), .ld_be(core_be),
    .hit, .covers, .fwd_data
  );

  sbuf_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk, .rst_n,
    .req_valid(core_valid), .req_kind(kind), .req_addr(core_addr),
    .req_wdata(core_wdata), .req_be(core_be),
    .hold(core_hold), .fwd_hit(hit), .sb_empty(fifo_empty),
    .head_addr(e_addr[head_idx]), .head_data(e_data[head_idx]), .head_be(e_be[head_idx]),
    .mem_ack, .mem_rdata,
    .mem_req, .mem_we, .mem_io, .mem_addr, .mem_wdata, .mem_be,
    .pop, .done(bus_done), .rsp_data
  );

  p_hold_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_hold && !bus_done |-> !core_ready);
  p_fwd_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_go |-> !(mem_req && !mem_we && !mem_io && mem_addr == core_addr));
  p_hold_until_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_hold && !pop |=> core_hold);
  p_full_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && !pop |=> fifo_full);

endmodule

// File: tb/sim_sbuf_top.sv
`timescale 1ns/1ps
module sim_sbuf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_valid = 1'b0;
  logic [1:0]  core_kind = 2'd0;
  logic [3:0]  core_addr = 4'd0;
  logic [31:0] core_wdata = 32'd0;
  logic [3:0]  core_be = 4'd0;
  logic        core_ready;
  logic [31:0] core_rdata;
  logic        ev_locked = 1'b0, ev_store_fence = 1'b0, ev_full_fence = 1'b0;
  logic        ev_interrupt = 1'b0, ev_serialize = 1'b0;
  logic        core_hold, sb_empty;
  logic        mem_req, mem_we, mem_io;
  logic [3:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'd0;

  always #2.5 clk = ~clk;

  sbuf_top #(.DEPTH(4), .AW(4), .DW(32)) u0 (
    .clk, .rst_n, .core_valid, .core_kind, .core_addr, .core_wdata, .core_be,
    .core_ready, .core_rdata, .ev_locked, .ev_store_fence, .ev_full_fence,
    .ev_interrupt, .ev_serialize, .core_hold, .sb_empty,
    .mem_req, .mem_we, .mem_io, .mem_addr, .mem_wdata, .mem_be, .mem_ack, .mem_rdata
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] refm [16], bmem [16], iom [16], ioref [16];
  logic [3:0]  ord_a [1024];
  logic [31:0] ord_d [1024];
  logic [3:0]  ord_b [1024];
  int w_head = 0, w_tail = 0, rd_cnt = 0, lat = 1, mcnt = 0;
  bit mstall = 0, bypass_seen = 0;
  logic [3:0] held_addr;

  function automatic logic [31:0] bmask(input logic [3:0] be);
    logic [31:0] m = 32'd0;
    for (int i = 0; i < 4; i++) if (be[i]) m = m | (32'hFF << (8 * i));
    return m;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    return (old & ~bmask(be)) | (nw & bmask(be));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // bus memory model, acts on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && rst_n) begin
        if (mcnt == 0) held_addr = mem_addr;
        else if (mem_addr !== held_addr) check(0, "R9 address moved", 32'(mem_addr), 32'(held_addr));
        mcnt++;
        if (!mstall && mcnt >= lat) begin
          mcnt = 0;
          mem_ack = 1'b1;
          if (mem_io) begin
            check(sb_empty == 1'b1, mem_we ? "R6 io write with stores buffered" : "R7 io read with stores buffered",
                  32'(sb_empty), 32'd1);
            if (mem_we) iom[mem_addr] = merge(iom[mem_addr], mem_wdata, mem_be);
            else mem_rdata = iom[mem_addr];
          end else if (mem_we) begin
            check(w_head < w_tail && mem_addr == ord_a[w_head] && mem_wdata == ord_d[w_head] &&
                  mem_be == ord_b[w_head], "R1 store write order", {mem_be, 24'(mem_addr)}, {ord_b[w_head], 24'(ord_a[w_head])});
            bmem[mem_addr] = merge(bmem[mem_addr], mem_wdata, mem_be);
            w_head++;
          end else begin
            rd_cnt++;
            if (!sb_empty) bypass_seen = 1;
            mem_rdata = bmem[mem_addr];
          end
        end
      end
    end
  end

  // first: 0 no check, 1 expect stall on first cycle, 2 expect accept on first cycle
  task automatic do_req(input int kind, input int a, input logic [31:0] d, input logic [3:0] be,
                        input logic [4:0] ev, input int first, input string tag,
                        output logic [31:0] rd, output int waits);
    bit got = 0;
    @(negedge clk);
    core_valid = 1'b1; core_kind = 2'(kind); core_addr = 4'(a); core_wdata = d; core_be = be;
    {ev_locked, ev_store_fence, ev_full_fence, ev_interrupt, ev_serialize} = ev;
    #1;
    if (ev != 0 && !sb_empty) begin
      check(core_hold == 1'b1, {tag, " R5 hold on event"}, 32'(core_hold), 32'd1);
      check(core_ready == 1'b0, {tag, " R5 request blocked"}, 32'(core_ready), 32'd0);
    end
    if (first == 1) check(core_ready == 1'b0, {tag, " stall expected"}, 32'(core_ready), 32'd0);
    if (first == 2) check(core_ready == 1'b1, {tag, " immediate accept expected"}, 32'(core_ready), 32'd1);
    mstall = 0;
    waits = 0;
    while (!got) begin
      if (core_ready) got = 1;
      else begin
        @(negedge clk);
        {ev_locked, ev_store_fence, ev_full_fence, ev_interrupt, ev_serialize} = 5'd0;
        #1;
        if (ev != 0 && waits == 0 && !sb_empty)
          check(core_hold == 1'b1, {tag, " R5 hold persists"}, 32'(core_hold), 32'd1);
        waits++;
        if (waits > 3000) begin
          check(0, {tag, " watchdog: request never completed"}, 32'(waits), 32'd0);
          got = 1;
        end
      end
    end
    rd = core_rdata;
    if (ev != 0) check(sb_empty == 1'b1, {tag, " R5 drained before accept"}, 32'(sb_empty), 32'd1);
    @(posedge clk); #1;
    core_valid = 1'b0;
    {ev_locked, ev_store_fence, ev_full_fence, ev_interrupt, ev_serialize} = 5'd0;
    if (kind == 1) begin
      refm[a] = merge(refm[a], d, be);
      ord_a[w_tail] = 4'(a); ord_d[w_tail] = d; ord_b[w_tail] = be; w_tail++;
    end
    if (kind == 3) ioref[a] = merge(ioref[a], d, be);
  endtask

  task automatic st(input int a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] rd; int w;
    do_req(1, a, d, be, 5'd0, 0, "R1 store", rd, w);
  endtask

  task automatic ld_chk(input int a, input logic [3:0] be, input int first, input string tag);
    logic [31:0] rd, exp; int w;
    exp = refm[a];
    do_req(0, a, 32'd0, be, 5'd0, first, tag, rd, w);
    check((rd & bmask(be)) == (exp & bmask(be)), tag, rd & bmask(be), exp & bmask(be));
  endtask

  task automatic wait_empty();
    int n = 0;
    do begin @(negedge clk); #1; n++; end while (!(sb_empty && !mem_req) && n < 3000);
    check(sb_empty == 1'b1, "R11 buffer drains", 32'(sb_empty), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int w, r0;
    logic [15:0] lf;
    for (int i = 0; i < 16; i++) begin
      bmem[i] = 32'h1000_0000 + 32'(i) * 32'h0101; refm[i] = bmem[i];
      iom[i] = 32'hA000_0000 + 32'(i); ioref[i] = iom[i];
    end
    repeat (3) @(negedge clk);
    #1;
    check(sb_empty == 1'b1 && mem_req == 1'b0 && core_hold == 1'b0 && core_ready == 1'b0,
          "R10 reset state", {28'd0, sb_empty, mem_req, core_hold, core_ready}, 32'h8);
    @(negedge clk); rst_n = 1'b1;

    // R11 flag after one store
    lat = 3;
    st(2, 32'hCAFE_0002, 4'hF);
    #0 check(sb_empty == 1'b0, "R11 nonempty after store", 32'(sb_empty), 32'd0);
    wait_empty();

    // R2 bypass: distinct stores then unrelated load
    bypass_seen = 0;
    st(1, 32'h1111_1111, 4'hF); st(2, 32'h2222_2222, 4'hF); st(3, 32'h3333_3333, 4'hF);
    ld_chk(9, 4'hF, 1, "R2 load bypass data");
    check(bypass_seen == 1, "R2 read issued with stores buffered", 32'(bypass_seen), 32'd1);
    wait_empty();

    // R3 forward newest, no bus read
    mstall = 1;
    st(4, 32'hAAAA_0001, 4'hF); st(4, 32'hBBBB_0002, 4'hF);
    r0 = rd_cnt;
    ld_chk(4, 4'hF, 2, "R3 forward newest entry");
    ld_chk(4, 4'h2, 2, "R3 forward subset bytes");
    check(rd_cnt == r0, "R3 no bus read on forward", 32'(rd_cnt), 32'(r0));
    mstall = 0;
    wait_empty();

    // R4 partial overlap
    lat = 2;
    st(6, 32'h6666_BEEF, 4'h3);
    r0 = rd_cnt;
    ld_chk(6, 4'hF, 1, "R4 partial overlap data");
    check(rd_cnt == r0 + 1, "R4 load read from memory", 32'(rd_cnt), 32'(r0 + 1));
    wait_empty();

    // R5 each drain event
    for (int e = 0; e < 5; e++) begin
      lat = 4;
      st(10, 32'h0E00_0000 + 32'(e), 4'hF); st(11, 32'h0F00_0000 + 32'(e), 4'hF);
      do_req(1, 12, 32'h0D00_0000 + 32'(e), 4'hF, 5'(1 << e), 0, "R5 event", rd, w);
      check(w > 0, "R5 core stalled for drain", 32'(w), 32'd1);
      wait_empty();
      #0 check(core_hold == 1'b0, "R5 hold released", 32'(core_hold), 32'd0);
    end

    // R6 / R7 io behind buffered stores
    lat = 3;
    st(13, 32'h1313_1313, 4'hF); st(14, 32'h1414_1414, 4'hF);
    do_req(3, 5, 32'h5555_AAAA, 4'hF, 5'd0, 1, "R6 io write", rd, w);
    check(sb_empty == 1'b1, "R6 io write not buffered", 32'(sb_empty), 32'd1);
    check(iom[5] == ioref[5], "R6 io write landed", iom[5], ioref[5]);
    st(15, 32'h1515_1515, 4'hF);
    do_req(2, 5, 32'd0, 4'hF, 5'd0, 1, "R7 io read", rd, w);
    check(rd == ioref[5], "R7 io read data", rd, ioref[5]);

    // R8 full buffer
    wait_empty();
    mstall = 1;
    for (int i = 0; i < 4; i++) st(i, 32'h8000_0000 + 32'(i), 4'hF);
    do_req(1, 7, 32'h8888_0007, 4'hF, 5'd0, 1, "R8 full store stall", rd, w);
    wait_empty();

    // sweep: every address and four byte-enable patterns, then full load
    lat = 1;
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 16; a++) begin
        logic [3:0] be;
        be = (p == 0) ? 4'hF : (p == 1) ? 4'h3 : (p == 2) ? 4'hC : 4'h1;
        st(a, 32'h5A00_0000 + 32'(p << 8) + 32'(a), be);
        ld_chk(a, 4'hF, 0, (be == 4'hF) ? "R3 sweep forward" : "R4 sweep partial");
      end
    end

    // pseudo-random mix
    lf = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      int a, k;
      logic [3:0] be;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = int'(lf[2:0]);
      k = int'(lf[5:3]);
      be = (lf[7:6] == 2'd0) ? 4'hF : (lf[7:6] == 2'd1) ? 4'h3 : (lf[7:6] == 2'd2) ? 4'hC : 4'h2;
      lat = 1 + int'(lf[9:8]);
      if (k < 4) st(a, {lf, lf ^ 16'h3C3C}, be);
      else if (k < 6) ld_chk(a, be, 0, "R11 mixed load data");
      else if (k == 6) begin
        do_req(lf[10] ? 3 : 2, a, {lf ^ 16'h1234, lf}, be, lf[11] ? 5'(1 << (n % 5)) : 5'd0, 0,
               "R7 mixed io", rd, w);
        if (!lf[10]) check((rd & bmask(be)) == (ioref[a] & bmask(be)), "R7 mixed io read", rd, ioref[a]);
      end else
        do_req(1, a, {lf, 16'hF00D}, be, 5'(1 << (n % 5)), 0, "R5 mixed event store", rd, w);
    end

    wait_empty();
    for (int i = 0; i < 16; i++) begin
      check(bmem[i] == refm[i], "R1 final memory image", bmem[i], refm[i]);
      check(iom[i] == ioref[i], "R6 final io image", iom[i], ioref[i]);
    end
    check(w_head == w_tail, "R1 every store written once", 32'(w_head), 32'(w_tail));
    finish_run();
  end
endmodule